// File: doc/BRIEF.md
# Presettable Binary/Decade Up-Down Counter

A four-bit counter that steps once per rising clock edge, up or down, in plain binary (0 to 15) or BCD decade (0 to 9). The mode and direction can change at run time. An active-low carry input works as a count enable. An active-low carry output flags the terminal count in the current direction. The carry output is decoded combinationally from the present count, so it can be chained. The carry output of one counter feeds the carry input of the next, and counters that share one clock then behave as a multi-digit synchronous counter.

A preset input loads the four jam inputs into the count asynchronously, without waiting for a clock edge. While the preset is high the count follows the jam inputs and ignores the clock. Counting resumes from the loaded value on the first enabled edge after the preset is released. A synchronous active-low reset clears the count.

Top module: `bcd_updn_ctr`

## Requirements
- R1: While `rst_n` is low and `preset` is low, a rising clock edge clears `q` to 0.
- R2: While `preset` is high, `q` equals `jam` within the same clock period, with no clock edge needed. A later change of `jam` while `preset` stays high is also copied through. A low jam bit gives a 0 in that bit.
- R3: Clock edges do not change `q` while `preset` is high. The first enabled edge after `preset` falls steps from the loaded value.
- R4: `q` changes only on a rising edge with `cin_n` low, `preset` low and `rst_n` high. With `cin_n` high the count holds.
- R5: With `bin_sel` = 1 (binary), the count steps by one and wraps 15 to 0 going up (`up_sel` = 1) and 0 to 15 going down (`up_sel` = 0).
- R6: With `bin_sel` = 0 (decade), the count wraps 9 to 0 going up and 0 to 9 going down.
- R7: In decade mode, an enabled up step from any value 10 to 15 gives 0. An enabled down step from 10 to 15 subtracts one.
- R8: `co_n` is 0 exactly when `cin_n` is 0 and `q` is at the terminal count. The terminal count is 15 (binary) or 9 (decade) when counting up, and 0 when counting down. Otherwise `co_n` is 1.
- R9: `co_n` follows changes on `cin_n`, `up_sel` and `bin_sel` within the same clock period, with no clock edge.
- R10: Two counters on one clock, with the low stage's `co_n` driving the high stage's `cin_n`, count as a two-digit BCD or an 8-bit binary counter in both directions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge count clock |
| rst_n | input | 1 | Synchronous active-low clear |
| cin_n | input | 1 | Active-low carry in / count enable |
| bin_sel | input | 1 | 1 = binary, 0 = BCD decade |
| up_sel | input | 1 | 1 = count up, 0 = count down |
| preset | input | 1 | Asynchronous load of `jam` while high |
| jam | input | 4 | Preset value |
| q | output | 4 | Current count |
| co_n | output | 1 | Active-low terminal-count carry out |

## Verification
The hardest state to reach from the ports is a high stage in a cascade being enabled by the low stage's carry during a wrap. In the same stretch of cycles the mode or direction may change, or a preset may land with a BCD value of 10 to 15. The stimulus cascades two counters. It loads random jam values, illegal BCD codes included, through short preset pulses. It then runs random stretches with mode and direction flips while the carry input is mostly enabled. Directed cases load the count next to each wrap point.

// File: rtl/bcd_updn_pkg.sv
// Package: types and default sizes shared by the up/down counter blocks.
// Assumes a digit of at least four bits so a decade limit of 9 fits.
package bcd_updn_pkg;
    localparam int CNT_W   = 4;
    localparam int DEC_TOP = 9;

    // Counting configuration seen by the next-state and carry logic.
    typedef struct packed {
        logic bin;   // 1 = binary, 0 = decade
        logic up;    // 1 = up, 0 = down
    } cnt_mode_t;
endpackage

// File: rtl/bcd_updn_next.sv
// Next-count logic: from the present count and mode, gives the value
// one enabled step later. In decade mode an upward step from any value
// at or above the decade top returns to 0, and a downward step from an
// illegal value subtracts one.
module bcd_updn_next #(
    parameter int WIDTH   = bcd_updn_pkg::CNT_W,
    parameter int DEC_MAX = bcd_updn_pkg::DEC_TOP
) (
    input  logic [WIDTH-1:0]          cur,
    input  bcd_updn_pkg::cnt_mode_t   mode,
    output logic [WIDTH-1:0]          nxt
);
    localparam logic [WIDTH-1:0] DEC_LIM = WIDTH'(DEC_MAX);
    localparam logic [WIDTH-1:0] ONE     = WIDTH'(1);

    // Pick the stepped value for the selected mode and direction.
    always_comb begin
        if (mode.up) begin
            if (mode.bin)            nxt = cur + ONE;
            else if (cur >= DEC_LIM) nxt = '0;
            else                     nxt = cur + ONE;
        end else begin
            if (mode.bin)            nxt = cur - ONE;
            else if (cur == '0)      nxt = DEC_LIM;
            else                     nxt = cur - ONE;
        end
    end
endmodule

// File: rtl/bcd_updn_term.sv
// Look-ahead carry: flags the terminal count for the present direction
// and mode, gated by the active-low carry input. Purely combinational,
// so a chained stage sees the carry in the same cycle.
module bcd_updn_term #(
    parameter int WIDTH   = bcd_updn_pkg::CNT_W,
    parameter int DEC_MAX = bcd_updn_pkg::DEC_TOP
) (
    input  logic [WIDTH-1:0]          cur,
    input  bcd_updn_pkg::cnt_mode_t   mode,
    input  logic                      cin_n,
    output logic                      co_n
);
    localparam logic [WIDTH-1:0] DEC_LIM = WIDTH'(DEC_MAX);
    localparam logic [WIDTH-1:0] BIN_LIM = {WIDTH{1'b1}};

    logic at_end;

    // Decide whether the count sits at the end of its range.
    always_comb begin
        if (mode.up) at_end = (cur == (mode.bin ? BIN_LIM : DEC_LIM));
        else         at_end = (cur == '0);
    end

    // Drive the active-low carry only when counting is enabled.
    always_comb co_n = ~(at_end & ~cin_n);
endmodule

// File: rtl/bcd_updn_bit.sv
// One count bit: asynchronous set and clear from the preset path take
// priority. Otherwise the bit has a synchronous active-low clear and then
// a clocked load of the next value when enabled. Assumes set_a and
// clr_a are never high together.
module bcd_updn_bit (
    input  logic clk,
    input  logic rst_n,
    input  logic set_a,
    input  logic clr_a,
    input  logic en,
    input  logic d,
    output logic b
);
    // Hold state; the preset forces, then reset, then the enabled step.
    always_ff @(posedge clk or posedge set_a or posedge clr_a) begin
        if (set_a)       b <= 1'b1;
        else if (clr_a)  b <= 1'b0;
        else if (!rst_n) b <= 1'b0;
        else if (en)     b <= d;
    end
endmodule

// File: rtl/bcd_updn_ctr.sv
// Presettable binary/decade up-down counter. One bit cell per count bit
// takes an asynchronous set or clear from the jam inputs while preset is
// high. The cells step together on the clock when the carry input is
// low. The carry output is look-ahead logic, meant to drive the next
// stage's carry input in a counter chain that shares one clock.
module bcd_updn_ctr #(
    parameter int WIDTH   = bcd_updn_pkg::CNT_W,
    parameter int DEC_MAX = bcd_updn_pkg::DEC_TOP
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cin_n,
    input  logic             bin_sel,
    input  logic             up_sel,
    input  logic             preset,
    input  logic [WIDTH-1:0] jam,
    output logic [WIDTH-1:0] q,
    output logic             co_n
);
    bcd_updn_pkg::cnt_mode_t mode;
    logic [WIDTH-1:0]        q_nxt;
    logic                    step_en;

    // Gather the mode pins into one struct.
    always_comb begin
        mode.bin = bin_sel;
        mode.up  = up_sel;
    end

    // A step happens only when enabled and not presetting.
    always_comb step_en = ~cin_n & ~preset;

    bcd_updn_next #(.WIDTH(WIDTH), .DEC_MAX(DEC_MAX)) u_next (
        .cur (q),
        .mode(mode),
        .nxt (q_nxt)
    );

    bcd_updn_term #(.WIDTH(WIDTH), .DEC_MAX(DEC_MAX)) u_term (
        .cur  (q),
        .mode (mode),
        .cin_n(cin_n),
        .co_n (co_n)
    );

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        logic set_i;
        logic clr_i;
        // Split the preset into a per-bit set or clear.
        always_comb begin
            set_i = preset &  jam[i];
            clr_i = preset & ~jam[i];
        end
        bcd_updn_bit u_bit (
            .clk  (clk),
            .rst_n(rst_n),
            .set_a(set_i),
            .clr_a(clr_i),
            .en   (step_en),
            .d    (q_nxt[i]),
            .b    (q[i])
        );
    end
endmodule

// File: rtl/bcd_updn_ctr_chk.sv
// Checker for the up/down counter, bound to every instance of the top.
module bcd_updn_ctr_chk #(
    parameter int WIDTH   = bcd_updn_pkg::CNT_W,
    parameter int DEC_MAX = bcd_updn_pkg::DEC_TOP
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cin_n,
    input logic             bin_sel,
    input logic             up_sel,
    input logic             preset,
    input logic [WIDTH-1:0] jam,
    input logic [WIDTH-1:0] q,
    input logic             co_n
);
    localparam logic [WIDTH-1:0] DEC_LIM = WIDTH'(DEC_MAX);

    // R2
    preset_follows_jam_chk: assert property (@(posedge clk) disable iff (!rst_n)
        preset |-> (q == jam));

    // R4
    hold_when_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!preset && cin_n) |=> (preset || $stable(q)));

    // R5
    binary_up_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!preset && !cin_n && bin_sel && up_sel) |=>
            (preset || q == WIDTH'($past(q) + WIDTH'(1))));

    // R7
    decade_up_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!preset && !cin_n && !bin_sel && up_sel && q >= DEC_LIM) |=>
            (preset || q == '0));

    // R8
    carry_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !co_n |-> !cin_n);

    // R8
    carry_at_terminal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !co_n |-> (q == '0 || q == DEC_LIM || q == {WIDTH{1'b1}}));
endmodule

bind bcd_updn_ctr bcd_updn_ctr_chk #(.WIDTH(WIDTH), .DEC_MAX(DEC_MAX)) u_chk (
    .clk(clk), .rst_n(rst_n), .cin_n(cin_n), .bin_sel(bin_sel),
    .up_sel(up_sel), .preset(preset), .jam(jam), .q(q), .co_n(co_n)
);

// File: tb/bcd_updn_ctr_tb.sv
// Bench: two counters chained on one clock (low stage u_dut, high stage
// u_hi), checked each cycle against a bench model of the pair.
module bcd_updn_ctr_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cin_n = 1'b1;
    logic       bin_sel = 1'b1;
    logic       up_sel = 1'b1;
    logic       preset = 1'b0;
    logic [3:0] jam_lo = 4'd0;
    logic [3:0] jam_hi = 4'd0;
    logic [3:0] q_lo, q_hi;
    logic       co_lo, co_hi;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [3:0] m_lo = 4'd0;
    logic [3:0] m_hi = 4'd0;

    always #4 clk = ~clk;

    bcd_updn_ctr u_dut (
        .clk(clk), .rst_n(rst_n), .cin_n(cin_n), .bin_sel(bin_sel),
        .up_sel(up_sel), .preset(preset), .jam(jam_lo), .q(q_lo), .co_n(co_lo)
    );

    bcd_updn_ctr u_hi (
        .clk(clk), .rst_n(rst_n), .cin_n(co_lo), .bin_sel(bin_sel),
        .up_sel(up_sel), .preset(preset), .jam(jam_hi), .q(q_hi), .co_n(co_hi)
    );

    function automatic logic [3:0] nxt_f(input logic [3:0] v, input logic b, input logic u);
        if (u) return b ? 4'(v + 4'd1) : ((v >= 4'd9) ? 4'd0 : 4'(v + 4'd1));
        else   return b ? 4'(v - 4'd1) : ((v == 4'd0) ? 4'd9 : 4'(v - 4'd1));
    endfunction

    function automatic logic co_f(input logic [3:0] v, input logic b, input logic u, input logic ci);
        logic t;
        t = u ? (v == (b ? 4'd15 : 4'd9)) : (v == 4'd0);
        return ~(t & ~ci);
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // One cycle: drive at the falling edge, check the outputs, advance the model.
    task automatic cyc(input string req, input logic ci, input logic b, input logic u,
                       input logic pre, input logic [3:0] jl, input logic [3:0] jh);
        logic cl;
        @(negedge clk);
        cin_n = ci; bin_sel = b; up_sel = u; preset = pre; jam_lo = jl; jam_hi = jh;
        #1;
        if (pre) begin m_lo = jl; m_hi = jh; end
        cl = co_f(m_lo, b, u, ci);
        chk(req, {4'd0, q_lo}, {4'd0, m_lo});
        chk(req, {4'd0, q_hi}, {4'd0, m_hi});
        chk(req, {7'd0, co_lo}, {7'd0, cl});
        chk(req, {7'd0, co_hi}, {7'd0, co_f(m_hi, b, u, cl)});
        if (!pre) begin
            if (!cl) m_hi = nxt_f(m_hi, b, u);
            if (!ci) m_lo = nxt_f(m_lo, b, u);
        end
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        // R1: synchronous clear
        repeat (3) @(posedge clk);
        #1;
        chk("R1", {4'd0, q_lo}, 8'd0);
        chk("R1", {4'd0, q_hi}, 8'd0);
        chk("R1", {7'd0, co_lo}, 8'd1);
        @(negedge clk); rst_n = 1'b1;

        // R2: asynchronous load mid-cycle, then a jam change while held
        @(negedge clk); #2;
        preset = 1'b1; jam_lo = 4'b1010; jam_hi = 4'b0101;
        #1;
        chk("R2", {4'd0, q_lo}, 8'd10);
        chk("R2", {4'd0, q_hi}, 8'd5);
        jam_lo = 4'b0000;
        #1;
        chk("R2", {4'd0, q_lo}, 8'd0);
        m_lo = 4'd0; m_hi = 4'd5;

        // R3: frozen over enabled edges, then resumes from the jam value
        repeat (3) cyc("R3", 1'b0, 1'b1, 1'b1, 1'b1, 4'd7, 4'd2);
        repeat (2) cyc("R3", 1'b0, 1'b1, 1'b1, 1'b0, 4'd0, 4'd0);

        // R4: carry input high holds the count
        repeat (3) cyc("R4", 1'b1, 1'b1, 1'b1, 1'b0, 4'd0, 4'd0);

        // R5: binary wraps in both directions, chained to 8 bits
        cyc("R5", 1'b0, 1'b1, 1'b1, 1'b1, 4'd14, 4'd15);
        repeat (4) cyc("R5", 1'b0, 1'b1, 1'b1, 1'b0, 4'd0, 4'd0);
        cyc("R5", 1'b0, 1'b1, 1'b0, 1'b1, 4'd1, 4'd0);
        repeat (4) cyc("R5", 1'b0, 1'b1, 1'b0, 1'b0, 4'd0, 4'd0);

        // R6: decade wraps in both directions, chained to two digits
        cyc("R6", 1'b0, 1'b0, 1'b1, 1'b1, 4'd8, 4'd9);
        repeat (4) cyc("R6", 1'b0, 1'b0, 1'b1, 1'b0, 4'd0, 4'd0);
        cyc("R6", 1'b0, 1'b0, 1'b0, 1'b1, 4'd1, 4'd0);
        repeat (4) cyc("R6", 1'b0, 1'b0, 1'b0, 1'b0, 4'd0, 4'd0);

        // R7: illegal BCD values up and down
        cyc("R7", 1'b0, 1'b0, 1'b1, 1'b1, 4'd12, 4'd15);
        repeat (2) cyc("R7", 1'b0, 1'b0, 1'b1, 1'b0, 4'd0, 4'd0);
        cyc("R7", 1'b0, 1'b0, 1'b0, 1'b1, 4'd12, 4'd11);
        repeat (4) cyc("R7", 1'b0, 1'b0, 1'b0, 1'b0, 4'd0, 4'd0);

        // R8: carry at terminal counts, gated by carry in
        cyc("R8", 1'b1, 1'b1, 1'b1, 1'b1, 4'd15, 4'd9);
        cyc("R8", 1'b1, 1'b1, 1'b1, 1'b0, 4'd0, 4'd0);
        cyc("R8", 1'b0, 1'b0, 1'b1, 1'b1, 4'd9, 4'd0);
        cyc("R8", 1'b1, 1'b0, 1'b1, 1'b0, 4'd0, 4'd0);

        // R9: carry follows direction and enable with no edge
        cyc("R9", 1'b1, 1'b0, 1'b1, 1'b1, 4'd9, 4'd3);
        @(negedge clk); preset = 1'b0; cin_n = 1'b0; #1;
        chk("R9", {7'd0, co_lo}, 8'd0);
        up_sel = 1'b0; #1;
        chk("R9", {7'd0, co_lo}, 8'd1);
        bin_sel = 1'b1; up_sel = 1'b1; #1;
        chk("R9", {7'd0, co_lo}, 8'd1);
        cin_n = 1'b1; #1;
        chk("R9", {7'd0, co_lo}, 8'd1);

        // R10: random chained stimulus with presets and mode flips
        for (int i = 0; i < 600; i++) begin
            logic ci, b, u, p;
            ci = ($urandom % 8) == 0;
            p  = ($urandom % 20) == 0;
            b  = (i / 60) % 2 == 0;
            u  = (i / 30) % 2 == 0;
            if (($urandom % 40) == 0) u = ~u;
            cyc("R10", ci, b, u, p, 4'($urandom), 4'($urandom));
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule